// File: doc/BRIEF.md
# Programmable Debounce Filter for a Digital Input Bank

This block cleans a bank of digital inputs. A prescaler derives a base tick from the system clock, one tick per 100 µs time unit. A second counter turns that tick into a sample strobe every `ivl_cfg` base units. Each input bit has its own run counter. The filtered level of a bit moves to the opposite level only after a run of consecutive samples has all shown that level. The length of the run comes from the degree code. A single sample that agrees with the current level clears the run.

Both settings are live inputs. They may change at any time after reset, and they apply from the next sample strobe. An interval outside the legal range is clamped. An unknown degree code is treated as the deepest setting. When the enable input is low, the raw inputs appear at the output unchanged. The filter keeps tracking in the background while it is bypassed. Right after reset, every filtered bit takes the level seen in the first clock cycle, so the output never starts at an arbitrary value.

Top module: `din_filter_top`

## Requirements
- R1: While `rst` is high the filtered state is 0. In the first cycle after `rst` falls, every bit loads the raw level, whatever the degree and interval, so one clock edge later `filt_out` equals `raw_in` when `filt_en` is 1.
- R2: When `filt_en` is 0, `filt_out` equals `raw_in` in the same cycle, through combinational logic only.
- R3: A filtered bit changes only on a sample strobe, and only to the level that was sampled. It changes once N consecutive samples differ from it, and not after N-1.
- R4: A sample that matches the current filtered level clears the run. Pulses that stay shorter than N consecutive samples never reach `filt_out`.
- R5: `deg_cfg` selects N as follows: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8 and 4 gives 10. Every other code gives 10.
- R6: A base tick occurs every `TICK_CYCLES` clocks. A sample strobe occurs every `ivl_cfg` base ticks, so two strobes are `TICK_CYCLES*ivl_cfg` clocks apart.
- R7: An `ivl_cfg` of 0 acts as 1. An `ivl_cfg` above 10000 acts as 10000.
- R8: Every bit is filtered on its own. Activity on one bit never changes another bit's output.
- R9: A change of `ivl_cfg` or `deg_cfg` takes effect without a reset. When the interval drops below the time already counted, the very next base tick samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| filt_en | input | 1 | 1 selects the filtered levels, 0 passes the raw inputs |
| ivl_cfg | input | 14 | Sample interval in base time units (legal range 1 to 10000) |
| deg_cfg | input | 4 | Degree code that selects the consecutive-sample count |
| raw_in | input | W | Raw input levels |
| filt_out | output | W | Filtered or raw levels, as `filt_en` selects |

## Verification
Two things can land in the same cycle. A new setting can arrive while the interval counter already holds more than the new limit, and a sample strobe can find one bit completing its run while a neighbouring bit is only glitching. The bench provokes the first case by dropping the interval from 10000 to 1 in the middle of a count. It then requires the new level within one base tick. It provokes the second case by pulsing bit 7 for exactly one sample period while bit 0 completes a two-sample change, and it checks the whole vector on both sides of the commit strobe. The expected commit times come from window bounds. A change must not show after (N-1) sample periods and must show after N sample periods, whatever the phase of the strobe.

// File: rtl/dinf_pkg.sv
package dinf_pkg;

    localparam int IVL_W   = 14;
    localparam int DEG_W   = 4;
    localparam int IVL_MAX = 10000;
    localparam int DEG_MAX = 10;
    localparam int RUN_W   = $clog2(DEG_MAX + 1);

    typedef logic [IVL_W-1:0] ivl_t;
    typedef logic [DEG_W-1:0] deg_code_t;
    typedef logic [RUN_W-1:0] run_t;

    typedef enum logic [DEG_W-1:0] {
        DEG_ONE   = 4'd0,
        DEG_TWO   = 4'd1,
        DEG_FOUR  = 4'd2,
        DEG_EIGHT = 4'd3,
        DEG_TEN   = 4'd4
    } deg_e;

    typedef struct packed {
        logic lvl;
        run_t run;
    } bit_st_t;

    function automatic ivl_t clamp_ivl(input ivl_t v);
        if (v == '0)
            return ivl_t'(1);
        else if (v > ivl_t'(IVL_MAX))
            return ivl_t'(IVL_MAX);
        else
            return v;
    endfunction

    function automatic run_t decode_deg(input deg_code_t c);
        case (deg_e'(c))
            DEG_ONE:   return run_t'(1);
            DEG_TWO:   return run_t'(2);
            DEG_FOUR:  return run_t'(4);
            DEG_EIGHT: return run_t'(8);
            default:   return run_t'(DEG_MAX);
        endcase
    endfunction

endpackage

// File: rtl/dinf_tick_gen.sv
module dinf_tick_gen
    import dinf_pkg::*;
#(
    parameter int TICK_CYCLES = 10000
) (
    input  logic clk,
    input  logic rst,
    input  ivl_t ivl,
    output logic tick,
    output logic smp,
    output logic load
);
    localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;

    logic [PW-1:0] pcnt;
    ivl_t          icnt;
    logic          primed;
    logic          hit;

    assign tick = (pcnt == PW'(TICK_CYCLES - 1));
    assign hit  = (icnt >= ivl - ivl_t'(1));
    assign smp  = primed & tick & hit;
    assign load = ~primed & ~rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt   <= '0;
            icnt   <= '0;
            primed <= 1'b0;
        end else begin
            primed <= 1'b1;
            if (tick)
                pcnt <= '0;
            else
                pcnt <= pcnt + PW'(1);
            if (tick) begin
                if (hit)
                    icnt <= '0;
                else
                    icnt <= icnt + ivl_t'(1);
            end
        end
    end

endmodule

// File: rtl/dinf_bit.sv
module dinf_bit
    import dinf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic smp,
    input  logic raw,
    input  run_t need,
    output logic lvl
);
    bit_st_t st;
    run_t    nxt;

    assign nxt = st.run + run_t'(1);
    assign lvl = st.lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (load) begin
            st.lvl <= raw;
            st.run <= '0;
        end else if (smp) begin
            if (raw == st.lvl) begin
                st.run <= '0;
            end else if (nxt >= need) begin
                st.lvl <= raw;
                st.run <= '0;
            end else begin
                st.run <= nxt;
            end
        end
    end

endmodule

// File: rtl/din_filter_top.sv
module din_filter_top
    import dinf_pkg::*;
#(
    parameter int W           = 8,
    parameter int TICK_CYCLES = 10000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             filt_en,
    input  logic [13:0]      ivl_cfg,
    input  logic [3:0]       deg_cfg,
    input  logic [W-1:0]     raw_in,
    output logic [W-1:0]     filt_out
);
    ivl_t         ivl_use;
    run_t         need;
    logic         tick;
    logic         smp;
    logic         load;
    logic [W-1:0] lvl_vec;

    assign ivl_use = clamp_ivl(ivl_cfg);
    assign need    = decode_deg(deg_cfg);

    dinf_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .ivl  (ivl_use),
        .tick (tick),
        .smp  (smp),
        .load (load)
    );

    for (genvar i = 0; i < W; i++) begin : g_bit
        dinf_bit u_bit (
            .clk  (clk),
            .rst  (rst),
            .load (load),
            .smp  (smp),
            .raw  (raw_in[i]),
            .need (need),
            .lvl  (lvl_vec[i])
        );
    end

    assign filt_out = filt_en ? lvl_vec : raw_in;

endmodule

// File: rtl/dinf_chk.sv
module dinf_chk #(
    parameter int W  = 8,
    parameter int TC = 10000
) (
    input logic         clk,
    input logic         rst,
    input logic [3:0]   deg_cfg,
    input logic [W-1:0] raw_in,
    input logic         smp,
    input logic         load,
    input logic [W-1:0] lvl
);
    localparam int GAP_MAX = TC * 10000;

    int   gap;
    logic seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap  <= 0;
            seen <= 1'b0;
        end else if (smp) begin
            gap  <= 0;
            seen <= 1'b1;
        end else if (gap < GAP_MAX + 1) begin
            gap <= gap + 1;
        end
    end

    // R1
    first_load_chk: assert property (@(posedge clk) disable iff (rst)
        $past(load) |-> (lvl == $past(raw_in)));

    // R3
    change_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (lvl != $past(lvl)) |-> ($past(smp) || $past(load)));

    // R3
    adopt_sampled_chk: assert property (@(posedge clk) disable iff (rst)
        ((lvl ^ $past(lvl)) & (lvl ^ $past(raw_in))) == '0);

    // R5
    degree_one_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(smp) && ($past(deg_cfg) == 4'd0)) |-> (lvl == $past(raw_in)));

    // R6
    strobe_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (smp && seen) |-> (gap >= TC - 1));

    // R7
    strobe_upper_chk: assert property (@(posedge clk) disable iff (rst)
        seen |-> (gap <= GAP_MAX));

endmodule

bind din_filter_top dinf_chk #(.W(W), .TC(TICK_CYCLES)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .deg_cfg (deg_cfg),
    .raw_in  (raw_in),
    .smp     (smp),
    .load    (load),
    .lvl     (lvl_vec)
);

// File: tb/sim_din_filter_top.sv
`timescale 1ns/1ps
module sim_din_filter_top;
    localparam int W  = 8;
    localparam int TC = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic         filt_en;
    logic [13:0]  ivl_cfg;
    logic [3:0]   deg_cfg;
    logic [W-1:0] raw_in;
    logic [W-1:0] filt_out;

    int total = 0;
    int bad   = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    din_filter_top #(.W(W), .TICK_CYCLES(TC)) u0 (
        .clk      (clk),
        .rst      (rst),
        .filt_en  (filt_en),
        .ivl_cfg  (ivl_cfg),
        .deg_cfg  (deg_cfg),
        .raw_in   (raw_in),
        .filt_out (filt_out)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic settle(input int p);
        step(11 * p + 8);
    endtask

    task automatic window(input string tag, input int n, input int p,
                          input logic [W-1:0] from, input logic [W-1:0] to);
        raw_in = to;
        if (n > 1) begin
            step((n - 1) * p);
            chk(tag, filt_out, from);
        end
        step(p);
        chk(tag, filt_out, to);
    endtask

    task automatic t_reset();
        rst = 1'b1; filt_en = 1'b1; ivl_cfg = 14'd1; deg_cfg = 4'd4; raw_in = 8'h5A;
        step(3);
        chk("R1 during reset", filt_out, 8'h00);
        rst = 1'b0;
        step(1);
        chk("R1 first sample", filt_out, 8'h5A);
    endtask

    task automatic t_bypass();
        filt_en = 1'b0;
        raw_in = 8'h3C;
        #1;
        chk("R2 bypass", filt_out, 8'h3C);
        #2 raw_in = 8'hC3;
        #1;
        chk("R2 bypass same cycle", filt_out, 8'hC3);
        raw_in = 8'h5A;
        filt_en = 1'b1;
        step(2);
    endtask

    task automatic t_degrees();
        ivl_cfg = 14'd1;
        deg_cfg = 4'd0; raw_in = 8'h00; settle(4);
        window("R5 code0 N=1", 1, 4, 8'h00, 8'hA5);
        deg_cfg = 4'd1; settle(4);
        window("R5 code1 N=2", 2, 4, 8'hA5, 8'h00);
        deg_cfg = 4'd2; settle(4);
        window("R3 code2 N=4", 4, 4, 8'h00, 8'hA5);
        deg_cfg = 4'd3; settle(4);
        window("R5 code3 N=8", 8, 4, 8'hA5, 8'h00);
        deg_cfg = 4'd4; settle(4);
        window("R5 code4 N=10", 10, 4, 8'h00, 8'hA5);
        deg_cfg = 4'd7; settle(4);
        window("R5 code7 N=10", 10, 4, 8'hA5, 8'h00);
        deg_cfg = 4'd15; settle(4);
        window("R5 code15 N=10", 10, 4, 8'h00, 8'hA5);
    endtask

    task automatic t_glitch();
        ivl_cfg = 14'd2; deg_cfg = 4'd2; raw_in = 8'h00; settle(8);
        chk("R4 start", filt_out, 8'h00);
        raw_in = 8'hFF; step(24);
        chk("R4 short pulse 1", filt_out, 8'h00);
        raw_in = 8'h00; step(8);
        raw_in = 8'hFF; step(24);
        chk("R4 short pulse 2", filt_out, 8'h00);
        raw_in = 8'h00; step(8);
        chk("R4 restart", filt_out, 8'h00);
    endtask

    task automatic t_interval();
        deg_cfg = 4'd1;
        ivl_cfg = 14'd5; raw_in = 8'h00; settle(20);
        window("R6 ivl5", 2, 20, 8'h00, 8'h0F);
        ivl_cfg = 14'd3; settle(12);
        window("R6 ivl3", 2, 12, 8'h0F, 8'hF0);
    endtask

    task automatic t_clamp();
        deg_cfg = 4'd1; ivl_cfg = 14'd0; settle(4);
        window("R7 ivl0 as 1", 2, 4, 8'hF0, 8'h11);
        deg_cfg = 4'd0; ivl_cfg = 14'd16383; step(8);
        raw_in = 8'h22;
        step(4 * 10000);
        chk("R7 ivl above max", filt_out, 8'h22);
    endtask

    task automatic t_runtime();
        deg_cfg = 4'd0; ivl_cfg = 14'd10000; step(100);
        ivl_cfg = 14'd1; raw_in = 8'h44;
        step(4);
        chk("R9 lowered interval", filt_out, 8'h44);
    endtask

    task automatic t_indep();
        deg_cfg = 4'd1; ivl_cfg = 14'd1; raw_in = 8'h00; settle(4);
        raw_in = 8'h81; step(4);
        chk("R8 before commit", filt_out, 8'h00);
        raw_in = 8'h01; step(4);
        chk("R8 bit0 only", filt_out, 8'h01);
        step(8);
        chk("R8 steady", filt_out, 8'h01);
    endtask

    initial begin
        step(1);
        t_reset();
        t_bypass();
        t_degrees();
        t_glitch();
        t_interval();
        t_clamp();
        t_runtime();
        t_indep();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1900000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule